// File: doc/BRIEF.md
# Dual-Partition Time and Space Firewall

This block keeps two software partitions that share one processor from disturbing each other. It enforces two kinds of separation. For time, a slice scheduler hands the processor to partition 0 and partition 1 in turn, and each partition holds it for a programmed number of cycles. For space, an address firewall checks every bus access against the memory window of whichever partition is active. Accesses to the other partition's window, or to anywhere outside the allowed windows, are refused.

Each partition also owns a thread-scheduling timer. That timer advances only while its partition holds the processor and keeps its count while the partition waits. A shared global window is open to both partitions. The check applies to external memory addresses as well as internal ones.

Software sets the block up through a simple register-write port. A master enable starts the alternating schedule. While the enable is low, partition 0 runs without interruption and no access is refused. A blocked access has its bus strobe suppressed and produces a one-cycle fault pulse that carries the ID of the offending partition.

Top module: `part_guard`

## Requirements
- R1: After reset the active partition is 0, the fault pulse is low and both thread interrupts are low.
- R2: While the enable bit (bit 0 of register 0x0) is 0, the active partition is 0 from the cycle after the enable is seen low. Every access with `bus_valid` high is granted in the same cycle and raises no fault.
- R3: When enabled, partition 0 is active for SL0+1 cycles and then partition 1 for SL1+1 cycles, alternating. SL0 and SL1 are the 16-bit slice reload values. Counting starts in the cycle after the enabling write.
- R4: An access by the active partition with base <= address <= limit of its own window is granted in the same cycle. Both bounds are inclusive.
- R5: An access that falls outside both the active partition's own window and the global window is refused: `bus_grant` is low in the same cycle. This includes an access to the other partition's window.
- R6: An access inside the global window is granted to either partition.
- R7: Each refused access raises `fault_pulse` for exactly the following cycle, with `fault_part` equal to the partition that was active during the access. An address presented with `bus_valid` low produces neither a grant nor a fault.
- R8: Each thread timer counts down only in cycles when its own partition is active and holds its value otherwise. It raises its interrupt bit for one cycle after every TR+1 active cycles, where TR is its reload value. A timer's interrupt never appears unless its partition was active in the previous cycle.
- R9: Register map (write-only, `cfg_addr` codes): 0x0 control (bit 0 enable), 0x1/0x2 slice reload for partition 0/1, 0x3/0x4 thread reload for partition 0/1 (a write also restarts that timer), 0x5/0x6 base/limit of partition 0, 0x7/0x8 base/limit of partition 1, 0x9/0xA base/limit of the global window. Reset leaves all windows empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| bus_valid | input | 1 | Bus access strobe from the processor |
| bus_addr | input | ADDR_W | Address of the bus access |
| bus_grant | output | 1 | Strobe passed to memory; low when the access is refused |
| fault_pulse | output | 1 | One-cycle pulse after a refused access |
| fault_part | output | 1 | Partition that caused the fault |
| active_part | output | 1 | Currently active partition |
| thr_irq | output | 2 | Thread timer interrupts, bit p for partition p |

## Verification
A slice counter that is off by one shows up at `active_part` within one schedule period, because every switch lands one cycle early or late. A wrong active-partition register shows up in the same cycle at `bus_grant`, because the window it selects is the other partition's. A thread timer that keeps counting while its partition waits raises its interrupt more often over a fixed run of whole schedule periods. It may also raise that interrupt just after the other partition's cycles. A lost or stretched fault register is visible one cycle after the refused access.

// File: rtl/part_guard_pkg.sv
package part_guard_pkg;

    localparam int NUM_PART = 2;
    localparam int NUM_WIN  = 3;   // windows 0 and 1 per partition, 2 shared
    localparam int GLB_WIN  = 2;
    localparam int CFG_AW   = 4;

    typedef enum logic [CFG_AW-1:0] {
        CR_CTRL   = 4'h0,
        CR_SLICE0 = 4'h1,
        CR_SLICE1 = 4'h2,
        CR_THR0   = 4'h3,
        CR_THR1   = 4'h4,
        CR_BASE0  = 4'h5,
        CR_LIM0   = 4'h6,
        CR_BASE1  = 4'h7,
        CR_LIM1   = 4'h8,
        CR_GBASE  = 4'h9,
        CR_GLIM   = 4'hA
    } cfg_reg_e;

endpackage

// File: rtl/pg_cfg_regs.sv
module pg_cfg_regs
    import part_guard_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SLICE_W = 16,
    parameter int THR_W   = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [CFG_AW-1:0]                    addr,
    input  logic [ADDR_W-1:0]                    wdata,
    output logic                                 enable,
    output logic [NUM_PART-1:0][SLICE_W-1:0]     slice_rl,
    output logic [NUM_PART-1:0][THR_W-1:0]       thr_rl,
    output logic [NUM_PART-1:0]                  thr_load,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]       win_base,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]       win_lim
);

    typedef struct packed {
        logic                             en;
        logic [NUM_PART-1:0][SLICE_W-1:0] slice;
        logic [NUM_PART-1:0][THR_W-1:0]   thr;
        logic [NUM_PART-1:0]              load;
        logic [NUM_WIN-1:0][ADDR_W-1:0]   base;
        logic [NUM_WIN-1:0][ADDR_W-1:0]   lim;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    cfg_reg_e sel;

    assign sel = cfg_reg_e'(addr);

    always_comb begin
        st_d      = st_q;
        st_d.load = '0;
        if (we) begin
            case (sel)
                CR_CTRL:   st_d.en          = wdata[0];
                CR_SLICE0: st_d.slice[0]    = wdata[SLICE_W-1:0];
                CR_SLICE1: st_d.slice[1]    = wdata[SLICE_W-1:0];
                CR_THR0: begin
                    st_d.thr[0]  = wdata[THR_W-1:0];
                    st_d.load[0] = 1'b1;
                end
                CR_THR1: begin
                    st_d.thr[1]  = wdata[THR_W-1:0];
                    st_d.load[1] = 1'b1;
                end
                CR_BASE0:  st_d.base[0]       = wdata;
                CR_LIM0:   st_d.lim[0]        = wdata;
                CR_BASE1:  st_d.base[1]       = wdata;
                CR_LIM1:   st_d.lim[1]        = wdata;
                CR_GBASE:  st_d.base[GLB_WIN] = wdata;
                CR_GLIM:   st_d.lim[GLB_WIN]  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= 1'b0;
            st_q.slice <= '1;
            st_q.thr   <= '1;
            st_q.load  <= '0;
            st_q.base  <= '1;
            st_q.lim   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable   = st_q.en;
    assign slice_rl = st_q.slice;
    assign thr_rl   = st_q.thr;
    assign thr_load = st_q.load;
    assign win_base = st_q.base;
    assign win_lim  = st_q.lim;

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_load)) else $error("two timer loads at once"); // R9

endmodule

// File: rtl/pg_slice_sched.sv
module pg_slice_sched
    import part_guard_pkg::*;
#(
    parameter int SLICE_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             enable,
    input  logic [NUM_PART-1:0][SLICE_W-1:0] slice_rl,
    output logic                             active
);

    typedef struct packed {
        logic               act;
        logic [SLICE_W-1:0] cnt;
    } sch_st_t;

    sch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.act = 1'b0;
            st_d.cnt = slice_rl[0];
        end else if (st_q.cnt == '0) begin
            st_d.act = ~st_q.act;
            st_d.cnt = slice_rl[~st_q.act];
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= 1'b0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;

    AST_SWITCH_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(!enable || st_q.cnt == '0)) else $error("early switch"); // R3
    AST_OFF_RUNS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !active) else $error("partition 1 while off"); // R2

endmodule

// File: rtl/pg_thread_timer.sv
module pg_thread_timer #(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [THR_W-1:0] reload,
    output logic             irq
);

    typedef struct packed {
        logic             irq;
        logic [THR_W-1:0] cnt;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.cnt = reload;
        end else if (run) begin
            if (st_q.cnt == '0) begin
                st_d.irq = 1'b1;
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    AST_IRQ_ONLY_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run)) else $error("irq from idle partition"); // R8
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(st_q.cnt)) else $error("idle timer moved"); // R8

endmodule

// File: rtl/pg_win_chk.sv
module pg_win_chk
    import part_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic                           active,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_base,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] win_lim,
    input  logic                           bus_valid,
    input  logic [ADDR_W-1:0]              bus_addr,
    output logic                           grant,
    output logic                           fault,
    output logic                           fault_part
);

    typedef struct packed {
        logic flt;
        logic part;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic [NUM_WIN-1:0] hit;
    logic own_hit;
    logic allowed;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign hit[w] = (bus_addr >= win_base[w]) && (bus_addr <= win_lim[w]);
    end

    assign own_hit = active ? hit[1] : hit[0];
    assign allowed = !enable || own_hit || hit[GLB_WIN];
    assign grant   = bus_valid && allowed;

    always_comb begin
        st_d.flt  = bus_valid && !allowed;
        st_d.part = st_d.flt ? active : st_q.part;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flt  <= 1'b0;
            st_q.part <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault      = st_q.flt;
    assign fault_part = st_q.part;

    AST_FAULT_FOLLOWS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(bus_valid && !grant)) else $error("fault without block"); // R7
    AST_FAULT_ID: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_part == $past(active))) else $error("wrong fault id"); // R7
    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> bus_valid) else $error("grant without strobe"); // R5

endmodule

// File: rtl/part_guard.sv
module part_guard
    import part_guard_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SLICE_W = 16,
    parameter int THR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_grant,
    output logic                fault_pulse,
    output logic                fault_part,
    output logic                active_part,
    output logic [NUM_PART-1:0] thr_irq
);

    logic                             en;
    logic [NUM_PART-1:0][SLICE_W-1:0] slice_rl;
    logic [NUM_PART-1:0][THR_W-1:0]   thr_rl;
    logic [NUM_PART-1:0]              thr_load;
    logic [NUM_WIN-1:0][ADDR_W-1:0]   win_base;
    logic [NUM_WIN-1:0][ADDR_W-1:0]   win_lim;

    pg_cfg_regs #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .THR_W(THR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .enable   (en),
        .slice_rl (slice_rl),
        .thr_rl   (thr_rl),
        .thr_load (thr_load),
        .win_base (win_base),
        .win_lim  (win_lim)
    );

    pg_slice_sched #(.SLICE_W(SLICE_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (en),
        .slice_rl (slice_rl),
        .active   (active_part)
    );

    for (genvar p = 0; p < NUM_PART; p++) begin : g_thr
        pg_thread_timer #(.THR_W(THR_W)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (active_part == 1'(p)),
            .load   (thr_load[p]),
            .reload (thr_rl[p]),
            .irq    (thr_irq[p])
        );
    end

    pg_win_chk #(.ADDR_W(ADDR_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (en),
        .active     (active_part),
        .win_base   (win_base),
        .win_lim    (win_lim),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .grant      (bus_grant),
        .fault      (fault_pulse),
        .fault_part (fault_part)
    );

    AST_OFF_ALL_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (bus_grant == bus_valid)) else $error("refused while off"); // R2
    AST_IRQ1_AFTER_P1: assert property (@(posedge clk) disable iff (!rst_n)
        thr_irq[1] |-> $past(active_part)) else $error("irq1 from p0 time"); // R8

endmodule

// File: tb/sim_part_guard.sv
module sim_part_guard;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_grant, fault_pulse, fault_part, active_part;
    logic [1:0]    thr_irq;

    part_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_grant(bus_grant), .fault_pulse(fault_pulse), .fault_part(fault_part),
        .active_part(active_part), .thr_irq(thr_irq)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    item_t it;
    int    cyc_cnt = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    logic [31:0] got;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    function automatic logic [31:0] sample(int sel);
        case (sel)
            0:       return 32'(active_part);
            1:       return 32'(bus_grant);
            2:       return 32'(fault_pulse);
            3:       return 32'(fault_part);
            default: return 32'(thr_irq);
        endcase
    endfunction

    // monitor: pops items due this cycle and compares away from the edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cyc_cnt) begin
            it  = sb.pop_front();
            got = sample(it.sel);
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic want(int sel, logic [31:0] exp, string req);
        sb.push_back('{cyc_cnt, sel, exp, req});
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(logic [3:0] a, logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic access(logic [AW-1:0] a, logic g, string req);
        bus_valid = 1'b1; bus_addr = a;
        want(1, 32'(g), req);
        tick();
        bus_valid = 1'b0;
    endtask

    task automatic blocked(logic [AW-1:0] a, logic p, string req);
        access(a, 1'b0, req);
        want(2, 32'd1, "R7 pulse");
        want(3, 32'(p), "R7 id");
        tick();
        want(2, 32'd0, "R7 single cycle");
        tick();
    endtask

    task automatic wait_active(logic p);
        while (active_part == p) tick();
        while (active_part != p) tick();
    endtask

    initial begin
        int   n0, n1, bad;
        logic prev;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        want(0, 32'd0, "R1 active");
        want(2, 32'd0, "R1 fault");
        want(4, 32'd0, "R1 irq");
        tick();

        // R2: disabled, any address allowed
        access(32'h5000_0000, 1'b1, "R2 grant while off");
        want(2, 32'd0, "R2 no fault while off");
        tick();

        // R9 register map
        cfg_write(4'h5, 32'h0000_1000);
        cfg_write(4'h6, 32'h0000_1FFF);
        cfg_write(4'h7, 32'h0000_2000);
        cfg_write(4'h8, 32'h0000_2FFF);
        cfg_write(4'h9, 32'h0000_8000);
        cfg_write(4'hA, 32'h0000_80FF);
        cfg_write(4'h1, 32'd40);
        cfg_write(4'h2, 32'd40);
        cfg_write(4'h0, 32'd1);
        want(0, 32'd0, "R9 enable starts in p0");

        // partition 0 window checks
        access(32'h0000_1000, 1'b1, "R4 p0 base");
        access(32'h0000_1FFF, 1'b1, "R4 p0 limit");
        blocked(32'h0000_0FFF, 1'b0, "R5 p0 below base");
        blocked(32'h0000_2000, 1'b0, "R5 p0 into p1 window");
        access(32'h0000_8000, 1'b1, "R6 p0 global base");
        access(32'h0000_80FF, 1'b1, "R6 p0 global limit");
        blocked(32'h0000_8100, 1'b0, "R5 p0 past global");
        bus_valid = 1'b0; bus_addr = 32'h0000_2000;
        want(1, 32'd0, "R7 no grant without valid");
        tick();
        want(2, 32'd0, "R7 no fault without valid");

        // partition 1 window checks
        wait_active(1'b1);
        access(32'h0000_2000, 1'b1, "R4 p1 base");
        access(32'h0000_2FFF, 1'b1, "R4 p1 limit");
        blocked(32'h0000_1000, 1'b1, "R5 p1 into p0 window");
        blocked(32'h0000_3000, 1'b1, "R5 p1 past limit");
        access(32'h0000_8080, 1'b1, "R6 p1 global");

        // R2: turning off returns to p0 and opens all addresses
        cfg_write(4'h0, 32'd0);
        tick();
        want(0, 32'd0, "R2 p0 after disable");
        access(32'h0000_2000, 1'b1, "R2 grant after disable");

        // R3 schedule with SL0=3, SL1=5
        cfg_write(4'h1, 32'd3);
        cfg_write(4'h2, 32'd5);
        cfg_write(4'h3, 32'd3);
        cfg_write(4'h4, 32'd5);
        cfg_write(4'h0, 32'd1);
        for (int k = 0; k < 30; k++) begin
            want(0, ((k % 10) < 4) ? 32'd0 : 32'd1, "R3 slice order");
            tick();
        end

        // R8 thread timers over 10 whole schedule periods
        wait_active(1'b0);
        prev = 1'b1;
        n0 = 0; n1 = 0; bad = 0;
        for (int k = 0; k < 100; k++) begin
            if (thr_irq[0]) begin
                n0++;
                if (prev != 1'b0) bad++;
            end
            if (thr_irq[1]) begin
                n1++;
                if (prev != 1'b1) bad++;
            end
            prev = active_part;
            tick();
        end
        chk("R8 irq0 count", n0, 10);
        chk("R8 irq1 count", n1, 10);
        chk("R8 irq from idle partition", bad, 0);

        tick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule